// File: doc/BRIEF.md
# Supervisor Reset and Watchdog Unit

This block drives an active-low system reset from two sources. The first is a digital supply-good flag from an analog comparator. Reset is asserted as soon as that flag drops. It is released only after the flag has stayed high for a programmable number of clock cycles without a break. The second source is a watchdog fed by the serial chip-select line. Every accepted falling edge of chip-select restarts the watchdog. If the watchdog runs for a full timeout without such an edge, it issues a fixed-length reset pulse.

The timeout is chosen by a two-bit code that comes from nonvolatile storage. The block does not use a new code as soon as the storage changes. It takes the code up when a qualified chip-select frame ends, or while the supply is down. A bus-inhibit output follows the reset, so that a neighbouring serial slave drops and refuses traffic during any reset. All time constants are parameters counted in clock cycles.

Top module: `supv_reset_wdt`

## Requirements
- R1: While `supply_ok` is low, `sys_rst_n` is 0. After `supply_ok` rises, `sys_rst_n` goes to 1 exactly `HOLD_CYC` clock cycles later. Any low sample of `supply_ok` during that wait restarts the full count.
- R2: `bus_block` is 1 whenever `sys_rst_n` is 0, whichever source caused the reset. Chip-select activity during a reset neither restarts the watchdog nor takes up a new timeout code.
- R3: The active code selects the timeout: 2'b00 gives `TMO_SLOW` cycles, 2'b01 gives `TMO_MID` cycles and 2'b10 gives `TMO_FAST` cycles. The watchdog reset begins that many cycles after the last restart, where a restart is either a reset release or an accepted kick.
- R4: When the active code is 2'b11, the watchdog never fires, however long chip-select stays idle.
- R5: A watchdog reset lasts exactly `PULSE_CYC` cycles. When it ends, the watchdog count restarts from zero under the active code.
- R6: A kick is accepted only after `cs_n` has been sampled low on `KICK_MIN` consecutive clock edges. A shorter low pulse has no effect on the watchdog.
- R7: A new `wd_sel` value becomes active only at the rising edge of `cs_n` that ends a qualified low period (one of at least `KICK_MIN` samples), or while `supply_ok` is low. Changing `wd_sel` at any other time has no effect on the timeout.
- R8: If the newly active timeout is shorter than the time already elapsed, the watchdog reset begins on the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock; all time constants count its cycles |
| supply_ok | input | 1 | Supply-good flag from the threshold comparator, active high |
| cs_n | input | 1 | Serial chip-select, active low; also the watchdog kick |
| wd_sel | input | 2 | Stored watchdog timeout code |
| sys_rst_n | output | 1 | System reset, active low |
| bus_block | output | 1 | High while the serial slave must drop and refuse traffic |

## Verification
The bench builds the block with a hold of 20 cycles, a pulse of 8 cycles, timeouts of 120, 60 and 30 cycles and a four-sample kick filter. With these values every timeout code, the pulse restart and the filter edge (three low samples versus four) can be reached within a few hundred cycles. The fast timeout is short enough that a 100-cycle chip-select low outlasts it. This makes it possible to take up a shorter code after the count has already passed the new limit.

// File: rtl/supv_reset_wdt.sv
module supv_reset_wdt #(
  parameter int HOLD_CYC  = 200000,
  parameter int PULSE_CYC = 200000,
  parameter int TMO_SLOW  = 1400000,
  parameter int TMO_MID   = 600000,
  parameter int TMO_FAST  = 200000,
  parameter int KICK_MIN  = 1
) (
  input  logic       clk,
  input  logic       supply_ok,
  input  logic       cs_n,
  input  logic [1:0] wd_sel,
  output logic       sys_rst_n,
  output logic       bus_block
);

  localparam int M_A  = (HOLD_CYC > PULSE_CYC) ? HOLD_CYC : PULSE_CYC;
  localparam int M_B  = (TMO_SLOW > TMO_MID) ? TMO_SLOW : TMO_MID;
  localparam int M_C  = (M_A > M_B) ? M_A : M_B;
  localparam int TMAX = (M_C > TMO_FAST) ? M_C : TMO_FAST;
  localparam int CW   = $clog2(TMAX + 1);
  localparam int KW   = $clog2(KICK_MIN + 1);
  localparam logic [KW-1:0] K_LAST = KW'(KICK_MIN - 1);
  localparam logic [KW-1:0] K_FULL = KW'(KICK_MIN);
  localparam logic [1:0]    WD_OFF = 2'b11;

  typedef enum logic [1:0] {ST_PUP, ST_RUN, ST_WDR} phase_t;

  phase_t          phase;
  logic [CW-1:0]   tmr;
  logic [CW-1:0]   lim;
  logic [1:0]      wd_act;
  logic            cs_q;
  logic [KW-1:0]   lo_cnt;
  logic            kick;
  logic            cmd_done;

  always_comb begin
    case (wd_act)
      2'b00:   lim = CW'(TMO_SLOW);
      2'b01:   lim = CW'(TMO_MID);
      2'b10:   lim = CW'(TMO_FAST);
      default: lim = '0;
    endcase
  end

  assign kick      = (phase == ST_RUN) && !cs_q && (lo_cnt == K_LAST);
  assign cmd_done  = (phase == ST_RUN) && cs_q && (lo_cnt == K_FULL);
  assign sys_rst_n = (phase == ST_RUN);
  assign bus_block = !sys_rst_n;

  always_ff @(posedge clk) begin
    if (!supply_ok) begin
      phase  <= ST_PUP;
      tmr    <= '0;
      wd_act <= wd_sel;
      cs_q   <= 1'b1;
      lo_cnt <= '0;
    end else begin
      cs_q <= cs_n;
      if (phase != ST_RUN || cs_q)
        lo_cnt <= '0;
      else if (lo_cnt != K_FULL)
        lo_cnt <= lo_cnt + 1'b1;
      if (cmd_done)
        wd_act <= wd_sel;
      case (phase)
        ST_PUP: begin
          if (tmr == CW'(HOLD_CYC - 1)) begin
            phase <= ST_RUN;
            tmr   <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_RUN: begin
          if (kick || wd_act == WD_OFF) begin
            tmr <= '0;
          end else if (tmr >= lim - CW'(1)) begin
            phase <= ST_WDR;
            tmr   <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        ST_WDR: begin
          if (tmr == CW'(PULSE_CYC - 1)) begin
            phase <= ST_RUN;
            tmr   <= '0;
          end else begin
            tmr <= tmr + 1'b1;
          end
        end
        default: phase <= ST_PUP;
      endcase
    end
  end

  p_supply_low_r1: assert property (@(posedge clk)
    !supply_ok |=> (!sys_rst_n && bus_block));

  p_fire_r3: assert property (@(posedge clk) disable iff (!supply_ok)
    (phase == ST_RUN && wd_act != WD_OFF && !kick && tmr >= lim) |=> (phase == ST_WDR));

  p_off_r4: assert property (@(posedge clk) disable iff (!supply_ok)
    (phase == ST_RUN && wd_act == WD_OFF) |=> (phase == ST_RUN));

  p_pulse_r5: assert property (@(posedge clk) disable iff (!supply_ok)
    (phase == ST_WDR && tmr < CW'(PULSE_CYC - 1)) |=> (phase == ST_WDR && tmr == $past(tmr) + 1'b1));

  p_kick_r6: assert property (@(posedge clk) disable iff (!supply_ok)
    kick |=> (phase == ST_RUN && tmr == '0));

  p_code_r7: assert property (@(posedge clk) disable iff (!supply_ok)
    ($past(supply_ok) && wd_act != $past(wd_act)) |-> $past(cmd_done));

endmodule

// File: tb/test_supv_reset_wdt.sv
module test_supv_reset_wdt;
  localparam int CLK_P = 10;
  localparam int HOLD  = 20;
  localparam int PULSE = 8;
  localparam int TS    = 120;
  localparam int TM    = 60;
  localparam int TF    = 30;
  localparam int KMIN  = 4;
  localparam int NVEC  = 7;
  localparam int CAP   = 300;
  // code, idle cycles after release, chip-select low length
  localparam int VEC [NVEC][3] = '{
    '{0, 10, 4}, '{1, 5, 6}, '{2, 3, 4}, '{2, 3, 3},
    '{1, 0, 2},  '{3, 5, 4}, '{0, 50, 10}};

  logic       clk = 0;
  logic       supply_ok = 0;
  logic       cs_n = 1;
  logic [1:0] wd_sel = 2'b11;
  logic       sys_rst_n;
  logic       bus_block;
  int         errs = 0;
  int         checks = 0;
  int         cyc = 0;

  supv_reset_wdt #(.HOLD_CYC(HOLD), .PULSE_CYC(PULSE), .TMO_SLOW(TS), .TMO_MID(TM),
                   .TMO_FAST(TF), .KICK_MIN(KMIN)) i_supv_reset_wdt (
    .clk(clk), .supply_ok(supply_ok), .cs_n(cs_n), .wd_sel(wd_sel),
    .sys_rst_n(sys_rst_n), .bus_block(bus_block));

  always #(CLK_P/2) clk = ~clk;

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000) begin
      errs++;
      checks++;
      $display("FAIL watchdog: run hung, act=%0d exp<=150000", cyc);
      $display("Result: errors=%0d of %0d checks", errs, checks);
      $finish;
    end
  end

  function automatic int lim_of(input int code);
    case (code)
      0: return TS;
      1: return TM;
      2: return TF;
      default: return CAP;
    endcase
  endfunction

  task automatic check(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errs++;
      $display("FAIL %s: act=%0d exp=%0d", tag, act, exp);
    end
  endtask

  task automatic power_cycle(input logic [1:0] code);
    @(negedge clk);
    supply_ok = 0;
    wd_sel = code;
    cs_n = 1;
    repeat (3) @(negedge clk);
    supply_ok = 1;
  endtask

  task automatic wait_rel(input int n0);
    int n = n0;
    while (!sys_rst_n && n < HOLD + 50) begin
      @(negedge clk);
      n++;
    end
    check("R1 release delay", n, HOLD);
  endtask

  task automatic pulse(input int len);
    cs_n = 0;
    repeat (len) @(negedge clk);
    cs_n = 1;
  endtask

  task automatic meas(input int cap, output int n);
    n = 0;
    while (sys_rst_n && n < cap) begin
      @(negedge clk);
      n++;
    end
  endtask

  initial begin
    int n;
    repeat (3) @(negedge clk);
    check("R1 reset state", sys_rst_n, 0);
    check("R2 reset state bus_block", bus_block, 1);

    // table walk: R3 R4 R6
    for (int v = 0; v < NVEC; v++) begin
      int code = VEC[v][0];
      int d    = VEC[v][1];
      int l    = VEC[v][2];
      int exp;
      power_cycle(2'(code));
      wait_rel(0);
      repeat (d) @(negedge clk);
      pulse(l);
      if (code == 3)      exp = CAP;
      else if (l >= KMIN) exp = KMIN + lim_of(code) + 1 - l;
      else                exp = lim_of(code) - d - l;
      meas(CAP, n);
      check($sformatf("R3/R4/R6 vector %0d", v), n, exp);
    end

    // R1 brownout during hold restarts count
    power_cycle(2'b10);
    repeat (10) @(negedge clk);
    supply_ok = 0;
    @(negedge clk);
    check("R1 brownout holds reset", sys_rst_n, 0);
    supply_ok = 1;
    wait_rel(0);

    // R5 pulse length and restart; R2 bus_block during watchdog reset
    meas(CAP, n);
    check("R3 fast timeout", n, TF);
    check("R2 bus_block in watchdog reset", bus_block, 1);
    n = 0;
    while (!sys_rst_n && n < CAP) begin
      @(negedge clk);
      n++;
    end
    check("R5 pulse length", n, PULSE);
    meas(CAP, n);
    check("R5 restart after pulse", n, TF);

    // R2 chip-select during power-up hold is ignored
    power_cycle(2'b10);
    wd_sel = 2'b01;
    pulse(6);
    wait_rel(6);
    meas(CAP, n);
    check("R2 no take-up during reset", n, TF);

    // R7 code take-up only at end of qualified frame
    power_cycle(2'b11);
    wait_rel(0);
    wd_sel = 2'b10;
    meas(100, n);
    check("R7 no take-up without frame", n, 100);
    pulse(3);
    meas(100, n);
    check("R6 R7 short frame ignored", n, 100);
    pulse(5);
    meas(CAP, n);
    check("R7 take-up at frame end", n, TF + 2);

    // R8 shorter code after elapsed time exceeds it
    power_cycle(2'b00);
    wait_rel(0);
    wd_sel = 2'b10;
    pulse(100);
    meas(CAP, n);
    check("R8 immediate fire on shorter code", n, 3);

    $display("Result: errors=%0d of %0d checks", errs, checks);
    $finish;
  end
endmodule